// File: doc/BRIEF.md
# Programmed-IO Halfword Data FIFO

This block buffers transfer data between a 16-bit software data port and the serial data-line engine of a card host. Software moves each 32-bit word as two consecutive halfword accesses, low halfword first. Within a halfword, byte 0 sits in bits 7:0 and byte 1 in bits 15:8. The block stores halfwords unchanged and in arrival order, so this byte and halfword ordering passes through as is. Transfer lengths are always whole words.

A small controller sets which side may fill the FIFO and which side may drain it. It has three states. In `ST_IDLE` nothing moves. `ST_TX` is the host-to-card direction: software pushes and the line engine pops. `ST_RX` is the card-to-host direction: the line engine pushes and software pops. Four transitions exist. A start pulse in `ST_IDLE` enters `ST_TX` when `xfer_dir` is 0, or `ST_RX` when `xfer_dir` is 1, and that start also flushes the FIFO. A stop pulse in `ST_TX` or `ST_RX` returns to `ST_IDLE`. Every other combination holds the current state.

The ready flags come from the occupancy count on every cycle. They cover one free word for writing, one readable word, and a burst of eight readable words. They appear in an event vector, beside a status vector that carries empty, full and the two direction-active bits.

Top module: `pio_fifo_port`

## Requirements
- R1: After reset the state is `ST_IDLE`, the FIFO is empty, `pop_data` is 0, `ovf` is 0, `evt_flags` is 16'h0000 and `stat_flags` is 16'h2000.
- R2: The controller follows only the four named transitions. A start outside `ST_IDLE` is ignored. `stat_flags` bit 8 is set exactly in `ST_TX` and bit 9 exactly in `ST_RX`. An accepted start empties the FIFO and clears `ovf`.
- R3: In `ST_TX` only `host_wr` pushes and only `line_pop` pops. In `ST_RX` only `line_push` pushes and only `host_rd` pops. In `ST_IDLE` all four strobes are ignored.
- R4: Halfwords leave in the order they entered. `pop_data` shows the popped halfword from the clock edge that performs the pop.
- R5: `evt_flags` bit 4 (write-ready) is 1 exactly when the state is `ST_TX` and at least 2 halfword slots (one word) are free.
- R6: `evt_flags` bit 5 (read-ready) is 1 exactly when the state is `ST_RX` and at least 2 halfwords are stored.
- R7: `evt_flags` bit 10 (burst-ready) is 1 exactly when the state is `ST_RX` and at least 16 halfwords (eight words) are stored.
- R8: In every state, `stat_flags` bit 13 is 1 when the FIFO holds 0 halfwords and bit 12 is 1 when it holds 32. All bits of `evt_flags` and `stat_flags` not named in R2 and R5 to R8 read 0.
- R9: A push into a full FIFO is dropped and sets `ovf`. `ovf` then stays 1 until the next accepted start.
- R10: A pop from an empty FIFO leaves `pop_data` unchanged and the FIFO stays empty.
- R11: When a push and a pop happen in the same cycle on a FIFO that is neither empty nor full, both take effect and the occupancy does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Start pulse, honoured only in `ST_IDLE` |
| xfer_dir | input | 1 | Direction for the start: 0 host-to-card, 1 card-to-host |
| xfer_stop | input | 1 | Stop pulse, returns to `ST_IDLE` |
| host_wr | input | 1 | Software halfword write strobe |
| host_wdata | input | 16 | Software write halfword |
| host_rd | input | 1 | Software halfword read strobe |
| line_push | input | 1 | Line engine push strobe |
| line_wdata | input | 16 | Line engine push halfword |
| line_pop | input | 1 | Line engine pop strobe |
| pop_data | output | 16 | Last popped halfword |
| evt_flags | output | 16 | Ready events: bit 4 write, bit 5 read, bit 10 burst |
| stat_flags | output | 16 | Status: bit 13 empty, bit 12 full, bit 9 rx, bit 8 tx |
| ovf | output | 1 | Sticky overflow |

## Verification
The assertions assume one thing about the inputs: a start pulse and a stop pulse are never asserted in the same cycle. The checks on overflow stickiness and on the held pop value also rely on the start being the only way to flush the FIFO. The bench drives every strobe for exactly one cycle and never sends a start and a stop together. The ignored-strobe cases are issued only in states where R3 says they have no effect, and the result is read through `pop_data` and the flag vectors.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_RX   = 2'd2
    } xfer_state_t;

    localparam int EVT_WR_RDY = 4;
    localparam int EVT_RD_RDY = 5;
    localparam int EVT_RD8    = 10;
    localparam int STS_TX     = 8;
    localparam int STS_RX     = 9;
    localparam int STS_FULL   = 12;
    localparam int STS_EMPTY  = 13;
endpackage

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl
    import pio_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        dir,
    input  logic        stop,
    output xfer_state_t state,
    output logic        flush
);
    xfer_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = dir ? ST_RX : ST_TX;
            ST_TX:   if (stop)  nxt = ST_IDLE;
            ST_RX:   if (stop)  nxt = ST_IDLE;
            default:            nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        flush = (state == ST_IDLE) && start;
    end
endmodule

// File: rtl/pio_fifo_store.sv
module pio_fifo_store #(
    parameter int DEPTH = 32,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic [W-1:0]  pop_data,
    output logic          ovf
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, empty, push_ok, pop_ok;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wp] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp       <= '0;
            rp       <= '0;
            count    <= '0;
            pop_data <= '0;
            ovf      <= 1'b0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push_ok) wp <= adv(wp);
            if (pop_ok) begin
                rp       <= adv(rp);
                pop_data <= mem[rp];
            end
            count <= count + CW'(push_ok) - CW'(pop_ok);
            if (push && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/pio_fifo_flags.sv
module pio_fifo_flags
    import pio_fifo_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int WORD_HW     = 2,
    parameter int BURST_WORDS = 8,
    localparam int CW         = $clog2(DEPTH + 1),
    localparam int BURST_HW   = BURST_WORDS * WORD_HW
) (
    input  xfer_state_t   state,
    input  logic [CW-1:0] count,
    output logic [15:0]   evt,
    output logic [15:0]   sts
);
    logic [CW-1:0] free_slots;

    always_comb begin
        free_slots      = CW'(DEPTH) - count;
        evt             = '0;
        sts             = '0;
        evt[EVT_WR_RDY] = (state == ST_TX) && (free_slots >= CW'(WORD_HW));
        evt[EVT_RD_RDY] = (state == ST_RX) && (count >= CW'(WORD_HW));
        evt[EVT_RD8]    = (state == ST_RX) && (count >= CW'(BURST_HW));
        sts[STS_TX]     = (state == ST_TX);
        sts[STS_RX]     = (state == ST_RX);
        sts[STS_FULL]   = (count == CW'(DEPTH));
        sts[STS_EMPTY]  = (count == '0);
    end
endmodule

// File: rtl/pio_fifo_port.sv
module pio_fifo_port
    import pio_fifo_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int BURST_WORDS = 8,
    localparam int W          = 16,
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_start,
    input  logic          xfer_dir,
    input  logic          xfer_stop,
    input  logic          host_wr,
    input  logic [W-1:0]  host_wdata,
    input  logic          host_rd,
    input  logic          line_push,
    input  logic [W-1:0]  line_wdata,
    input  logic          line_pop,
    output logic [W-1:0]  pop_data,
    output logic [15:0]   evt_flags,
    output logic [15:0]   stat_flags,
    output logic          ovf
);
    xfer_state_t   state;
    logic          flush, push, pop;
    logic [W-1:0]  pdata;
    logic [CW-1:0] occ;

    pio_fifo_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (xfer_start),
        .dir   (xfer_dir),
        .stop  (xfer_stop),
        .state (state),
        .flush (flush)
    );

    always_comb begin
        push  = 1'b0;
        pop   = 1'b0;
        pdata = host_wdata;
        unique case (state)
            ST_TX: begin
                push  = host_wr;
                pop   = line_pop;
                pdata = host_wdata;
            end
            ST_RX: begin
                push  = line_push;
                pop   = host_rd;
                pdata = line_wdata;
            end
            default: ;
        endcase
    end

    pio_fifo_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (pdata),
        .pop       (pop),
        .count     (occ),
        .pop_data  (pop_data),
        .ovf       (ovf)
    );

    pio_fifo_flags #(.DEPTH(DEPTH), .BURST_WORDS(BURST_WORDS)) u_flags (
        .state (state),
        .count (occ),
        .evt   (evt_flags),
        .sts   (stat_flags)
    );
endmodule

// File: rtl/pio_fifo_port_chk.sv
module pio_fifo_port_chk #(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_start,
    input logic [15:0]   pop_data,
    input logic [15:0]   evt_flags,
    input logic [15:0]   stat_flags,
    input logic          ovf,
    input logic [CW-1:0] occ
);
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_flags[8] && stat_flags[9])); // R2
    AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_flags[4] && evt_flags[5])); // R5
    AST_BURST_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        evt_flags[10] |-> evt_flags[5]); // R7
    AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_flags[12] && stat_flags[13])); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !xfer_start) |=> ovf); // R9
    AST_OVF_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(stat_flags[12])); // R9
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stat_flags[13] |=> $stable(pop_data)); // R10
endmodule

bind pio_fifo_port pio_fifo_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .pop_data   (pop_data),
    .evt_flags  (evt_flags),
    .stat_flags (stat_flags),
    .ovf        (ovf),
    .occ        (occ)
);

// File: tb/test_pio_fifo_port.sv
module test_pio_fifo_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 0, xfer_dir = 0, xfer_stop = 0;
    logic        host_wr = 0, host_rd = 0, line_push = 0, line_pop = 0;
    logic [15:0] host_wdata = '0, line_wdata = '0;
    logic [15:0] pop_data, evt_flags, stat_flags;
    logic        ovf;
    int          total = 0, fails = 0;

    always #5 clk = ~clk;

    pio_fifo_port i_pio_fifo_port (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_dir(xfer_dir),
        .xfer_stop(xfer_stop), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .line_push(line_push), .line_wdata(line_wdata),
        .line_pop(line_pop), .pop_data(pop_data), .evt_flags(evt_flags),
        .stat_flags(stat_flags), .ovf(ovf)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic d);
        xfer_start = 1; xfer_dir = d; step(); xfer_start = 0;
    endtask
    task automatic stop();
        xfer_stop = 1; step(); xfer_stop = 0;
    endtask
    task automatic hw(input logic [15:0] v);
        host_wr = 1; host_wdata = v; step(); host_wr = 0;
    endtask
    task automatic lpush(input logic [15:0] v);
        line_push = 1; line_wdata = v; step(); line_push = 0;
    endtask
    task automatic hrd();
        host_rd = 1; step(); host_rd = 0;
    endtask
    task automatic lpop();
        line_pop = 1; step(); line_pop = 0;
    endtask

    task automatic t_reset();
        chk("R1 evt", evt_flags, 16'h0000);
        chk("R1 stat", stat_flags, 16'h2000);
        chk("R1 pop_data", pop_data, 16'h0000);
        chk("R1 ovf", {15'd0, ovf}, 16'h0000);
    endtask

    task automatic t_fsm();
        start(0);
        chk("R2 tx stat", stat_flags, 16'h2100);
        chk("R5 empty tx ready", evt_flags, 16'h0010);
        start(1);
        chk("R2 start ignored in tx", stat_flags, 16'h2100);
        stop();
        chk("R2 stop to idle", stat_flags, 16'h2000);
        chk("R8 idle evt zero", evt_flags, 16'h0000);
    endtask

    task automatic t_tx();
        start(0);
        for (int i = 0; i < 30; i++) hw(16'hA000 + 16'(i));
        chk("R5 two free", evt_flags, 16'h0010);
        hw(16'hA01E);
        chk("R5 one free", evt_flags, 16'h0000);
        lpop();
        chk("R4 tx order first", pop_data, 16'hA000);
        hrd();
        chk("R3 host_rd ignored in tx", pop_data, 16'hA000);
        lpop();
        chk("R4 tx order second", pop_data, 16'hA001);
        hw(16'hA01F); hw(16'hA020); hw(16'hA021);
        chk("R8 full in tx", stat_flags, 16'h1100);
        stop();
        chk("R8 full kept in idle", stat_flags, 16'h1000);
    endtask

    task automatic t_rx();
        start(1);
        chk("R2 rx flush", stat_flags, 16'h2200);
        lpush(16'hB000);
        chk("R6 one halfword", evt_flags, 16'h0000);
        lpush(16'hB001);
        chk("R6 one word", evt_flags, 16'h0020);
        for (int i = 2; i < 15; i++) lpush(16'hB000 + 16'(i));
        chk("R7 fifteen", evt_flags, 16'h0020);
        lpush(16'hB00F);
        chk("R7 sixteen", evt_flags, 16'h0420);
        hrd();
        chk("R4 rx order", pop_data, 16'hB000);
        chk("R7 back to fifteen", evt_flags, 16'h0020);
        hw(16'hEEEE);
        line_pop = 1; step(); line_pop = 0;
        chk("R3 line_pop ignored in rx", pop_data, 16'hB000);
        for (int i = 1; i < 16; i++) begin
            hrd();
            chk("R3 R4 rx drain", pop_data, 16'hB000 + 16'(i));
        end
        chk("R3 host_wr ignored in rx", stat_flags, 16'h2200);
        stop();
    endtask

    task automatic t_overflow();
        start(1);
        for (int i = 0; i < 32; i++) lpush(16'hC000 + 16'(i));
        chk("R8 full rx", stat_flags, 16'h1200);
        chk("R9 no ovf yet", {15'd0, ovf}, 16'h0000);
        lpush(16'hDEAD);
        chk("R9 ovf set", {15'd0, ovf}, 16'h0001);
        for (int i = 0; i < 32; i++) hrd();
        chk("R9 drop kept last", pop_data, 16'hC01F);
        chk("R8 empty rx", stat_flags, 16'h2200);
        hrd();
        chk("R10 empty pop hold", pop_data, 16'hC01F);
        chk("R10 still empty", stat_flags, 16'h2200);
        chk("R9 ovf sticky", {15'd0, ovf}, 16'h0001);
        stop();
        chk("R9 ovf survives stop", {15'd0, ovf}, 16'h0001);
        start(0);
        chk("R2 R9 start clears ovf", {15'd0, ovf}, 16'h0000);
        stop();
    endtask

    task automatic t_simul();
        start(0);
        for (int i = 0; i < 4; i++) hw(16'h5000 + 16'(i));
        for (int i = 0; i < 3; i++) begin
            host_wr = 1; host_wdata = 16'h5004 + 16'(i); line_pop = 1;
            step();
            host_wr = 0; line_pop = 0;
            chk("R11 simul pop order", pop_data, 16'h5000 + 16'(i));
        end
        for (int i = 3; i < 7; i++) begin
            lpop();
            chk("R11 simul drain", pop_data, 16'h5000 + 16'(i));
        end
        chk("R11 count kept four", stat_flags, 16'h2100);
        stop();
        hw(16'h7777); lpush(16'h8888);
        chk("R3 idle pushes ignored", stat_flags, 16'h2000);
        hrd(); lpop();
        chk("R3 idle pops ignored", pop_data, 16'h5006);
    endtask

    initial begin
        #2_000_000;
        fails++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        t_reset();
        t_fsm();
        t_tx();
        t_rx();
        t_overflow();
        t_simul();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule